// File: doc/BRIEF.md
# Boot ROM Region Decoder

This block sits on an internal host bus and decides, for each memory access, whether it falls inside the boot ROM space. Two windows alias the same ROM. One is a low window that ends at the top of the first megabyte. The other is a high window that ends at the top of the 32-bit address space. Both are live from reset. Separate configuration bits widen each window. When the block claims an access, it runs a fixed-length ISA-style memory cycle. The cycle drives an active-low ROM chip select and an active-low read or write strobe for a parameterised number of clocks. A one-clock done pulse follows.

Writes into the ROM space are normally refused. A write-enable configuration bit allows flash-style programming; with it set, a write drives the memory-write strobe, the generic write strobe and the chip select together. The width indication reports an 8-bit or 16-bit ROM. It follows a strap that is captured while reset is held, unless a configuration override picks the width.

Top module: `boot_rom_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, claim and cyc_done are 0 and rom_cs_n, mem_rd_n, mem_wr_n and wr_n are all 1.
- R2: A valid read to any address from 000F0000h through 000FFFFFh is claimed (claim=1 in the request cycle), whatever the configuration bits are.
- R3: A valid read to any address from FFFC0000h through FFFFFFFFh is claimed, whatever the configuration bits are.
- R4: With cfg_hi_ext=1, reads anywhere from FF000000h through FFFFFFFFh are claimed.
- R5: With cfg_lo_ext=1, reads anywhere from 000E0000h through 000FFFFFh are claimed.
- R6: A valid access outside every enabled window gets claim=0, and every strobe stays at 1.
- R7: A claimed read drives rom_cs_n=0 and mem_rd_n=0, with mem_wr_n=1 and wr_n=1, for exactly STROBE_CLKS cycles. These cycles start on the cycle after the claim. Then all strobes return to 1 and cyc_done is 1 for that single following cycle.
- R8: With cfg_rom_wr_en=0, a write inside a window gets claim=0, and every strobe stays at 1.
- R9: With cfg_rom_wr_en=1, a write inside a window is claimed. It drives rom_cs_n=0, mem_wr_n=0 and wr_n=0 together, with mem_rd_n=1, for STROBE_CLKS cycles, and then pulses cyc_done.
- R10: bus_wide=1 means a 16-bit ROM and 0 means an 8-bit ROM. With cfg_width_ovr=0, bus_wide equals the value strap_wide held during reset, and later changes of strap_wide have no effect.
- R11: With cfg_width_ovr=1, bus_wide equals cfg_width_wide.
- R12: A request that arrives while a cycle is in progress gets claim=0 and neither lengthens nor restarts the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap captured while low |
| req_valid | input | 1 | Host access present this cycle |
| req_addr | input | 32 | Host memory address |
| req_write | input | 1 | 1 = write, 0 = read |
| strap_wide | input | 1 | Width strap, 1 = 16-bit |
| cfg_lo_ext | input | 1 | Widen low window to 128 KB |
| cfg_hi_ext | input | 1 | Widen high window to 16 MB |
| cfg_width_ovr | input | 1 | Use cfg_width_wide instead of strap |
| cfg_width_wide | input | 1 | Programmed width, 1 = 16-bit |
| cfg_rom_wr_en | input | 1 | Allow writes to the ROM space |
| claim | output | 1 | Access accepted this cycle |
| rom_cs_n | output | 1 | ROM chip select, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| wr_n | output | 1 | Generic write strobe, active low |
| bus_wide | output | 1 | ROM width, 1 = 16-bit |
| cyc_done | output | 1 | One-cycle pulse after a cycle ends |

## Verification
Several properties are checked on every cycle:
- the read and write strobes are never both active;
- no strobe is active without the chip select;
- a claimed write always has the write enable behind it;
- a claim always starts a cycle on the next clock, and no claim is made while a cycle runs;
- each strobe run lasts exactly STROBE_CLKS clocks.

Window boundaries, the strap latch and the width override can only be shown by the bench's scenarios. These include the edges just inside and just outside each window under each widening bit, a strap that changes after reset, and requests held through an active cycle.

// File: rtl/brd_pkg.sv
package brd_pkg;
  typedef logic [31:0] addr_t;

  // True when addr lies in the aligned 2**lg byte block that contains top.
  function automatic logic in_block(input addr_t addr, input addr_t top, input int lg);
    return (addr >> lg) == (top >> lg);
  endfunction

  // True when an access of this direction may be forwarded to the ROM.
  function automatic logic dir_allowed(input logic is_write, input logic wr_en);
    return !is_write || wr_en;
  endfunction
endpackage

// File: rtl/brd_window_match.sv
module brd_window_match
  import brd_pkg::*;
#(
  parameter addr_t LO_TOP     = 32'h000F_FFFF,
  parameter addr_t HI_TOP     = 32'hFFFF_FFFF,
  parameter int    LO_LG      = 16,
  parameter int    LO_EXT_LG  = 17,
  parameter int    HI_LG      = 18,
  parameter int    HI_EXT_LG  = 24
) (
  input  addr_t addr,
  input  logic  lo_ext,
  input  logic  hi_ext,
  output logic  hit_lo,
  output logic  hit_hi,
  output logic  hit
);
  localparam int NWIN = 2;
  logic [NWIN-1:0] base_hit, ext_hit, ext_on;

  assign ext_on = {hi_ext, lo_ext};

  genvar g;
  generate
    for (g = 0; g < NWIN; g++) begin : g_win
      localparam addr_t TOP = (g == 0) ? LO_TOP : HI_TOP;
      localparam int    BLG = (g == 0) ? LO_LG : HI_LG;
      localparam int    ELG = (g == 0) ? LO_EXT_LG : HI_EXT_LG;
      assign base_hit[g] = in_block(addr, TOP, BLG);
      assign ext_hit[g]  = ext_on[g] && in_block(addr, TOP, ELG);
    end
  endgenerate

  assign hit_lo = base_hit[0] | ext_hit[0];
  assign hit_hi = base_hit[1] | ext_hit[1];
  assign hit    = hit_lo | hit_hi;
endmodule

// File: rtl/brd_width_sel.sv
module brd_width_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  input  logic ovr,
  input  logic ovr_wide,
  output logic wide
);
  logic strap_q;

  // Strap is sampled on every clock while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap;
  end

  assign wide = ovr ? ovr_wide : strap_q;

  // R10
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));
endmodule

// File: rtl/brd_cycle_seq.sv
module brd_cycle_seq #(
  parameter int STROBE_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic busy,
  output logic is_wr,
  output logic done
);
  localparam int CW = $clog2(STROBE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STROBE_CLKS - 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      is_wr <= 1'b0;
      done  <= 1'b0;
      left  <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (left == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          left <= left - 1'b1;
        end
      end else if (start) begin
        busy  <= 1'b1;
        is_wr <= start_wr;
        left  <= LAST;
      end
    end
  end

  // Independent run-length counter for the checks below.
  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)     run_len <= '0;
    else if (busy)  run_len <= run_len + 1'b1;
    else            run_len <= '0;
  end

  // R7
  run_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < (CW+1)'(STROBE_CLKS)));
  // R7
  run_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == (CW+1)'(STROBE_CLKS)));
  // R12
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/boot_rom_decoder.sv
module boot_rom_decoder
  import brd_pkg::*;
#(
  parameter int STROBE_CLKS = 3,
  parameter int LO_LG       = 16,
  parameter int LO_EXT_LG   = 17,
  parameter int HI_LG       = 18,
  parameter int HI_EXT_LG   = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic        strap_wide,
  input  logic        cfg_lo_ext,
  input  logic        cfg_hi_ext,
  input  logic        cfg_width_ovr,
  input  logic        cfg_width_wide,
  input  logic        cfg_rom_wr_en,
  output logic        claim,
  output logic        rom_cs_n,
  output logic        mem_rd_n,
  output logic        mem_wr_n,
  output logic        wr_n,
  output logic        bus_wide,
  output logic        cyc_done
);
  logic hit_lo, hit_hi, addr_hit, dir_ok;
  logic busy, is_wr;

  brd_window_match #(
    .LO_TOP(32'h000F_FFFF), .HI_TOP(32'hFFFF_FFFF),
    .LO_LG(LO_LG), .LO_EXT_LG(LO_EXT_LG), .HI_LG(HI_LG), .HI_EXT_LG(HI_EXT_LG)
  ) u_match (
    .addr(req_addr), .lo_ext(cfg_lo_ext), .hi_ext(cfg_hi_ext),
    .hit_lo(hit_lo), .hit_hi(hit_hi), .hit(addr_hit)
  );

  assign dir_ok = dir_allowed(req_write, cfg_rom_wr_en);
  assign claim  = req_valid && !busy && addr_hit && dir_ok;

  brd_cycle_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(claim), .start_wr(req_write),
    .busy(busy), .is_wr(is_wr), .done(cyc_done)
  );

  brd_width_sel u_width (
    .clk(clk), .rst_n(rst_n), .strap(strap_wide),
    .ovr(cfg_width_ovr), .ovr_wide(cfg_width_wide), .wide(bus_wide)
  );

  assign rom_cs_n = !busy;
  assign mem_rd_n = !(busy && !is_wr);
  assign mem_wr_n = !(busy && is_wr);
  assign wr_n     = !(busy && is_wr);

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));
  // R6
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs_n |-> (mem_rd_n && mem_wr_n && wr_n));
  // R8
  write_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && req_write) |-> cfg_rom_wr_en);
  // R9
  write_strobes_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_n == wr_n));
  // R7
  claim_starts_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> !rom_cs_n);
  // R12
  no_claim_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs_n |-> !claim);
  // R7
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> (rom_cs_n && $past(!rom_cs_n)));
  // R6
  hit_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> (hit_lo || hit_hi));
endmodule

// File: tb/sim_boot_rom_decoder.sv
module sim_boot_rom_decoder;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, strap_wide = 1'b0;
  logic [31:0] req_addr = '0;
  logic cfg_lo_ext = 1'b0, cfg_hi_ext = 1'b0, cfg_width_ovr = 1'b0;
  logic cfg_width_wide = 1'b0, cfg_rom_wr_en = 1'b0;
  logic claim, rom_cs_n, mem_rd_n, mem_wr_n, wr_n, bus_wide, cyc_done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  boot_rom_decoder #(.STROBE_CLKS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .strap_wide(strap_wide), .cfg_lo_ext(cfg_lo_ext),
    .cfg_hi_ext(cfg_hi_ext), .cfg_width_ovr(cfg_width_ovr),
    .cfg_width_wide(cfg_width_wide), .cfg_rom_wr_en(cfg_rom_wr_en),
    .claim(claim), .rom_cs_n(rom_cs_n), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .wr_n(wr_n), .bus_wide(bus_wide), .cyc_done(cyc_done)
  );

  function automatic bit model_hit(input logic [31:0] a, input bit lo, input bit hi);
    bit r;
    r = (a >= 32'h000F0000 && a <= 32'h000FFFFF) || (a >= 32'hFFFC0000);
    if (lo && a >= 32'h000E0000 && a <= 32'h000FFFFF) r = 1;
    if (hi && a >= 32'hFF000000) r = 1;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobes(input string req, input bit cs, input bit rd, input bit wr);
    check(req, {rom_cs_n, mem_rd_n, mem_wr_n, wr_n}, {28'd0, !cs, !rd, !wr, !wr});
  endtask

  task automatic do_reset(input bit strap);
    rst_n = 0; strap_wide = strap; req_valid = 0;
    repeat (3) @(negedge clk);
    check("R1 claim in reset", claim, 0);
    strobes("R1 strobes in reset", 0, 0, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    strobes("R1 strobes after reset", 0, 0, 0);
    check("R1 done after reset", cyc_done, 0);
  endtask

  // Drives one access at a negedge and follows the cycle it produces.
  task automatic access(input string req, input logic [31:0] a, input bit w, input bit hold);
    bit exp_claim;
    exp_claim = model_hit(a, cfg_lo_ext, cfg_hi_ext) && (!w || cfg_rom_wr_en);
    req_addr = a; req_write = w; req_valid = 1;
    #1 check(req, claim, exp_claim);
    @(negedge clk);
    if (!hold) req_valid = 0;
    if (exp_claim) begin
      for (int i = 0; i < N; i++) begin
        if (i > 0) @(negedge clk);
        #1;
        strobes(w ? "R9 write strobes" : "R7 read strobes", 1, !w, w);
        if (hold) check("R12 no claim while busy", claim, 0);
      end
      @(negedge clk);
      req_valid = 0;
      #1;
      strobes("R7 strobes end", 0, 0, 0);
      check("R7 done pulse", cyc_done, 1);
      @(negedge clk);
      check("R7 done single", cyc_done, 0);
    end else begin
      req_valid = 0;
      #1 strobes(w ? "R8 no write strobes" : "R6 no strobes", 0, 0, 0);
      check("R6 no done", cyc_done, 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] pool [8];
    void'($urandom(32'd1234));
    do_reset(1'b1);

    // R10 strap latched, later strap changes ignored
    check("R10 strap latched", bus_wide, 1);
    strap_wide = 0; @(negedge clk);
    check("R10 strap frozen", bus_wide, 1);
    // R11 override
    cfg_width_ovr = 1; cfg_width_wide = 0; #1;
    check("R11 override 8-bit", bus_wide, 0);
    cfg_width_wide = 1; #1;
    check("R11 override 16-bit", bus_wide, 1);
    cfg_width_ovr = 0; #1;
    check("R10 back to strap", bus_wide, 1);
    @(negedge clk);

    // Directed window edges, base configuration
    access("R2 low base start", 32'h000F0000, 0, 0);
    access("R2 low top", 32'h000FFFFF, 0, 0);
    access("R6 below low", 32'h000EFFFF, 0, 0);
    access("R6 above low", 32'h00100000, 0, 0);
    access("R3 high base start", 32'hFFFC0000, 0, 0);
    access("R3 high top", 32'hFFFFFFFF, 0, 0);
    access("R6 below high", 32'hFFFBFFFF, 0, 0);
    // R4 / R5 widening
    cfg_hi_ext = 1; cfg_lo_ext = 1;
    access("R4 high ext start", 32'hFF000000, 0, 0);
    access("R4 high ext mid", 32'hFFFBFFFF, 0, 0);
    access("R6 below high ext", 32'hFEFFFFFF, 0, 0);
    access("R5 low ext start", 32'h000E0000, 0, 0);
    access("R6 below low ext", 32'h000DFFFF, 0, 0);
    cfg_hi_ext = 0; cfg_lo_ext = 0;
    // R8 / R9 writes
    access("R8 write refused", 32'h000F1234, 1, 0);
    cfg_rom_wr_en = 1;
    access("R9 write allowed", 32'hFFFC1000, 1, 0);
    access("R9 write outside", 32'h12345678, 1, 0);
    cfg_rom_wr_en = 0;
    // R12 requests held through a cycle
    access("R12 held read", 32'h000F8000, 0, 1);
    cfg_rom_wr_en = 1;
    access("R12 held write", 32'hFFFF0000, 1, 1);
    cfg_rom_wr_en = 0;

    // Constrained random
    pool = '{32'h000F0000, 32'h000E0000, 32'hFFFC0000, 32'hFF000000,
             32'hFE000000, 32'h000D0000, 32'h00100000, 32'h80000000};
    for (int k = 0; k < 200; k++) begin
      logic [31:0] a;
      a = pool[$urandom_range(7)] | ($urandom & 32'h0001FFFF);
      if ($urandom_range(3) == 0) a = $urandom;
      cfg_lo_ext = 1'($urandom_range(1));
      cfg_hi_ext = 1'($urandom_range(1));
      cfg_rom_wr_en = 1'($urandom_range(1));
      access("R2-window random", a, 1'($urandom_range(1)), 1'($urandom_range(1)));
    end
    cfg_lo_ext = 0; cfg_hi_ext = 0; cfg_rom_wr_en = 0;

    // R10 second reset with the other strap value
    do_reset(1'b0);
    check("R10 strap 8-bit", bus_wide, 0);
    strap_wide = 1; @(negedge clk);
    check("R10 strap frozen 8-bit", bus_wide, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule